// File: doc/BRIEF.md
# Sixteen-Bit Integer ALU with Stored Carry

This block is the integer execution unit of a small 16-bit processor. Each cycle it receives a decoded 5-bit operation code, a 2-bit function field, two register operands, a 5-bit unsigned immediate and an 8-bit immediate. It returns a result and a destination write strobe in the same cycle. One carry bit is held across instructions so that multi-word arithmetic and the branch logic can use it.

The result and write strobe are combinational in the inputs and in the stored carry. The carry register is updated on the rising clock edge that ends the instruction. Operations with no destination, or with an opcode outside the set below, leave the carry and the register file untouched. There is no separate issue strobe: the NOP code is the idle state.

Top module: `alu16_carry`

## Requirements
- R1: After reset the stored carry reads 0.
- R2: Opcode 1 adds `op_a` and `op_b` modulo 2^16. With function field 01 the stored carry is added in. With any other function value (00, 10, 11) the carry is ignored. The carry-out becomes the new carry, and the write strobe is high.
- R3: Opcode 2 subtracts `op_b` from `op_a` modulo 2^16. With function field 01 the stored carry is also subtracted as a borrow. With any other value it is ignored. The new carry is 1 exactly when the subtraction needed a borrow.
- R4: The logic and move opcodes write their result and leave the carry unchanged: 3 is AND, 4 is OR, 5 is XOR, 6 is the complement of `op_a`, and 9 copies `op_a`. The function field has no effect on them.
- R5: Opcode 7 shifts `op_a` one place left and opcode 8 shifts it one place right, both filling with 0. The bit shifted out becomes the new carry.
- R6: Opcode 10 adds and opcode 11 subtracts the zero-extended `imm5` (0 to 31) to or from `op_a`. The new carry is the carry-out or the borrow.
- R7: Opcode 12 puts `imm8` in result bits 15:8 and opcode 13 puts it in bits 7:0. The other byte is taken from `op_a`. The carry is unchanged.
- R8: Opcode 14 sets the carry to 1 and drives the write strobe low.
- R9: Opcode 0 and opcodes 15 to 31 drive the write strobe low and leave the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; carry updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the carry |
| opcode | input | 5 | Operation code |
| func | input | 2 | Function field selecting carry-in or borrow-in variants |
| op_a | input | 16 | First source operand; supplies the kept byte for byte loads |
| op_b | input | 16 | Second source operand |
| imm5 | input | 5 | Unsigned short immediate |
| imm8 | input | 8 | Byte immediate for byte loads |
| result | output | 16 | Destination value |
| wr_en | output | 1 | Destination write strobe |
| carry_q | output | 1 | Stored carry flag, readable by branch logic |

## Verification
The bench tests wrap-around at the top of the range: FFFF plus 1, and immediate addition past 16 bits. A design that drops the carry-out would leave the flag clear there. It chains an add-with-carry and a subtract-with-borrow right after operations that set the flag, and runs the plain forms with function value 11. A design that decodes only one function bit would fold the stale carry into the sum. It runs logic, move and byte-load operations while the flag is 1, and unused opcodes with the flag in both states. A design that writes those ops' flag would clear or set it. Shifts with 1 in the end bit check that the bit pushed out, not a neighbour, lands in the carry. The byte loads check that the kept byte is not zeroed.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_NOT  = 5'd6,
    OP_SHL  = 5'd7,
    OP_SHR  = 5'd8,
    OP_MOV  = 5'd9,
    OP_ADDI = 5'd10,
    OP_SUBI = 5'd11,
    OP_LDHI = 5'd12,
    OP_LDLO = 5'd13,
    OP_STC  = 5'd14
  } alu_op_e;

  // function field value that folds the stored carry/borrow in
  localparam logic [1:0] FN_WITH_CARRY = 2'b01;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 5
) (
  input  alu_op_e          op,
  input  logic [1:0]       fn,
  input  logic             cin,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             active
);
  localparam int PAD = WIDTH - IMM_W;

  // sum with carry-out in the top bit
  function automatic logic [WIDTH:0] sum_f(input logic [WIDTH-1:0] x,
                                           input logic [WIDTH-1:0] y,
                                           input logic ci);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  // difference; top bit is 1 when a borrow was needed
  function automatic logic [WIDTH:0] diff_f(input logic [WIDTH-1:0] x,
                                            input logic [WIDTH-1:0] y,
                                            input logic bi);
    return {1'b0, x} - {1'b0, y} - {{WIDTH{1'b0}}, bi};
  endfunction

  logic [WIDTH-1:0] imm_ext;
  logic             chain;
  logic [WIDTH:0]   wide;

  assign imm_ext = {{PAD{1'b0}}, imm};
  assign chain   = (fn == FN_WITH_CARRY) & cin;

  always_comb begin
    active = 1'b1;
    unique case (op)
      OP_ADD:  wide = sum_f(a, b, chain);
      OP_SUB:  wide = diff_f(a, b, chain);
      OP_ADDI: wide = sum_f(a, imm_ext, 1'b0);
      OP_SUBI: wide = diff_f(a, imm_ext, 1'b0);
      default: begin
        wide   = '0;
        active = 1'b0;
      end
    endcase
  end

  assign res  = wide[WIDTH-1:0];
  assign cout = wide[WIDTH];

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic [WIDTH/2-1:0] imm8,
  output logic [WIDTH-1:0]   res,
  output logic               active,
  output logic               shift_active,
  output logic               shift_out
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    res          = '0;
    active       = 1'b1;
    shift_active = 1'b0;
    shift_out    = 1'b0;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_MOV:  res = a;
      OP_SHL: begin
        res          = {a[WIDTH-2:0], 1'b0};
        shift_active = 1'b1;
        shift_out    = a[WIDTH-1];
      end
      OP_SHR: begin
        res          = {1'b0, a[WIDTH-1:1]};
        shift_active = 1'b1;
        shift_out    = a[0];
      end
      OP_LDHI: res = {imm8, a[HALF-1:0]};
      OP_LDLO: res = {a[WIDTH-1:HALF], imm8};
      default: active = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu16_flag.sv
module alu16_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic nxt,
  output logic carry_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   carry_q <= 1'b0;
    else if (upd) carry_q <= nxt;
  end
endmodule

// File: rtl/alu16_carry.sv
module alu16_carry
  import alu16_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int IMM_W  = 5,
  parameter int BYTE_W = WIDTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        opcode,
  input  logic [1:0]        func,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [IMM_W-1:0]  imm5,
  input  logic [BYTE_W-1:0] imm8,
  output logic [WIDTH-1:0]  result,
  output logic              wr_en,
  output logic              carry_q
);
  alu_op_e          op;
  logic [WIDTH-1:0] arith_res, logic_res;
  logic             arith_active, arith_cout;
  logic             logic_active, shift_active, shift_out;
  logic             stc_hit, flag_upd, flag_nxt;

  assign op = alu_op_e'(opcode);

  alu16_arith #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_arith (
    .op(op), .fn(func), .cin(carry_q), .a(op_a), .b(op_b), .imm(imm5),
    .res(arith_res), .cout(arith_cout), .active(arith_active)
  );

  alu16_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(op_a), .b(op_b), .imm8(imm8),
    .res(logic_res), .active(logic_active),
    .shift_active(shift_active), .shift_out(shift_out)
  );

  assign stc_hit  = (op == OP_STC);
  assign flag_upd = arith_active | shift_active | stc_hit;
  assign flag_nxt = arith_active ? arith_cout : (shift_active ? shift_out : 1'b1);

  alu16_flag u_flag (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd), .nxt(flag_nxt), .carry_q(carry_q)
  );

  assign wr_en  = arith_active | logic_active;
  assign result = arith_active ? arith_res : logic_res;

  // R1: reset clears the flag
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !carry_q);

  // R2: plain add carries out exactly when the sum wrapped below op_a
  p_add_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && func != FN_WITH_CARRY) |=> carry_q == $past(result < op_a));

  // R3: plain subtract borrows exactly when op_a < op_b
  p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB && func != FN_WITH_CARRY) |=> carry_q == $past(op_a < op_b));

  // R4: logic and move keep the flag
  p_logic_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOV}) |=> $stable(carry_q));

  // R5: left shift pushes the top bit into the flag
  p_shl_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHL) |=> carry_q == $past(op_a[WIDTH-1]));

  // R6: immediate add carries out exactly when the sum wrapped
  p_addi_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADDI) |=> carry_q == $past(result < op_a));

  // R7: high-byte load keeps the low byte of op_a
  p_ldhi_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LDHI) |-> result[BYTE_W-1:0] == op_a[BYTE_W-1:0]);

  // R8: set-carry leaves the flag at 1 without a write
  p_stc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stc_hit |-> !wr_en ##1 carry_q);

  // R9: idle and unused codes keep the flag
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !stc_hit) |=> $stable(carry_q));

endmodule

// File: tb/alu16_carry_tb.sv
`timescale 1ns/1ps
module alu16_carry_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opcode = '0;
  logic [1:0]  func = '0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [4:0]  imm5 = '0;
  logic [7:0]  imm8 = '0;
  logic [15:0] result;
  logic        wr_en, carry_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mc = 0;  // model carry

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic        c;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  alu16_carry u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .func(func), .op_a(op_a),
    .op_b(op_b), .imm5(imm5), .imm8(imm8), .result(result), .wr_en(wr_en),
    .carry_q(carry_q)
  );

  task automatic run(input int op, input int fn, input int a, input int b,
                     input int i5, input int i8, input string tag);
    exp_t e;
    int   v;
    int   x;
    @(negedge clk);
    opcode = op[4:0]; func = fn[1:0]; op_a = a[15:0]; op_b = b[15:0];
    imm5 = i5[4:0]; imm8 = i8[7:0];
    e.tag = tag; e.we = 1'b1; e.c = mc; v = 0;
    case (op)
      1:  begin x = a + b + ((fn == 1) ? int'(mc) : 0); v = x % 65536; e.c = (x > 65535); end
      2:  begin x = a - b - ((fn == 1) ? int'(mc) : 0); v = (x + 65536) % 65536; e.c = (x < 0); end
      3:  v = a & b;
      4:  v = a | b;
      5:  v = a ^ b;
      6:  v = 65535 - a;
      7:  begin v = (a * 2) % 65536; e.c = (a >= 32768); end
      8:  begin v = a / 2; e.c = (a % 2 == 1); end
      9:  v = a;
      10: begin x = a + i5; v = x % 65536; e.c = (x > 65535); end
      11: begin x = a - i5; v = (x + 65536) % 65536; e.c = (x < 0); end
      12: v = i8 * 256 + (a % 256);
      13: v = (a / 256) * 256 + i8;
      14: begin e.we = 1'b0; e.c = 1'b1; end
      default: e.we = 1'b0;
    endcase
    e.res = v[15:0];
    mc = e.c;
    q.push_back(e);
  endtask

  // monitor: result before the edge, carry after it
  initial begin
    exp_t        e;
    logic [15:0] r;
    logic        w;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        r = result;
        w = wr_en;
        @(posedge clk);
        #1;
        checks++;
        if (w !== e.we || (e.we && r !== e.res) || carry_q !== e.c) begin
          errors++;
          $display("FAIL %s: got res=%h we=%b c=%b expected res=%h we=%b c=%b",
                   e.tag, r, w, carry_q, e.res, e.we, e.c);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    checks++;
    if (carry_q !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got c=%b expected c=0", carry_q);
    end
    run(1, 0, 16'h1234, 16'h0101, 0, 0, "R2 add");
    run(1, 0, 16'hFFFF, 16'h0001, 0, 0, "R2 add wrap");
    run(1, 1, 16'h0010, 16'h0020, 0, 0, "R2 adc");
    run(14, 0, 0, 0, 0, 0, "R8 stc");
    run(1, 3, 16'h0005, 16'h0006, 0, 0, "R2 add fn11");
    run(14, 0, 0, 0, 0, 0, "R8 stc");
    run(1, 2, 16'hFFFF, 16'h0000, 0, 0, "R2 add fn10");
    run(2, 0, 16'h0001, 16'h0002, 0, 0, "R3 sub borrow");
    run(2, 1, 16'h000A, 16'h0003, 0, 0, "R3 sbb");
    run(2, 0, 16'h0007, 16'h0007, 0, 0, "R3 sub equal");
    run(14, 0, 0, 0, 0, 0, "R8 stc");
    run(3, 1, 16'hF0F0, 16'h3C3C, 0, 0, "R4 and");
    run(4, 0, 16'hF0F0, 16'h3C3C, 0, 0, "R4 or");
    run(5, 2, 16'hF0F0, 16'h3C3C, 0, 0, "R4 xor");
    run(6, 0, 16'h00FF, 0, 0, 0, "R4 not");
    run(9, 0, 16'hBEEF, 0, 0, 0, "R4 mov");
    run(7, 0, 16'h8001, 0, 0, 0, "R5 shl");
    run(8, 0, 16'h0002, 0, 0, 0, "R5 shr zero");
    run(8, 0, 16'h0001, 0, 0, 0, "R5 shr one");
    run(10, 0, 16'hFFF0, 0, 31, 0, "R6 addi wrap");
    run(11, 0, 16'h0005, 0, 31, 0, "R6 subi borrow");
    run(11, 0, 16'h0028, 0, 31, 0, "R6 subi");
    run(14, 0, 0, 0, 0, 0, "R8 stc");
    run(12, 0, 16'h1234, 0, 0, 8'hAB, "R7 load high");
    run(13, 0, 16'h1234, 0, 0, 8'hCD, "R7 load low");
    run(0, 0, 16'hFFFF, 16'hFFFF, 0, 0, "R9 nop");
    run(20, 1, 16'hFFFF, 16'h0001, 0, 0, "R9 code 20");
    run(31, 0, 16'h8000, 0, 0, 0, "R9 code 31");
    run(7, 0, 16'h4000, 0, 0, 0, "R5 shl clear");
    run(15, 0, 16'h8000, 16'h8000, 0, 0, "R9 code 15");
    run(0, 0, 0, 0, 0, 0, "R9 idle");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule